// File: doc/BRIEF.md
# Instruction Immediate Builder

This combinational unit takes a 32-bit RV32I instruction word and a 3-bit format code. It returns the 32-bit immediate operand that the instruction encodes. Each format scatters its immediate bits across the word in its own way. The unit gathers those bits back into order and fills the top of the result with copies of the sign bit. Branch and jump offsets get an implied zero in bit 0, and upper-immediate values get zeros in the twelve low bits.

The control block decodes the opcode and drives the format code. The result goes to the operand selector, the address adder or the PC adder. This unit does neither of those jobs: it only rebuilds the immediate.

Top module: `imm_gen`

## Requirements
- R1: With fmt_sel = 0 (I format), imm_out[11:0] = instr_word[31:20], and imm_out[31:12] are copies of instr_word[31].
- R2: With fmt_sel = 1 (S format), imm_out[11:5] = instr_word[31:25] and imm_out[4:0] = instr_word[11:7], and imm_out[31:12] are copies of instr_word[31].
- R3: With fmt_sel = 2 (B format), imm_out[12] = instr_word[31], imm_out[11] = instr_word[7], imm_out[10:5] = instr_word[30:25], imm_out[4:1] = instr_word[11:8] and imm_out[0] = 0.
- R4: With fmt_sel = 3 (J format), imm_out[20] = instr_word[31], imm_out[19:12] = instr_word[19:12], imm_out[11] = instr_word[20], imm_out[10:1] = instr_word[30:21] and imm_out[0] = 0.
- R5: With fmt_sel = 4 (U format), imm_out[31:12] = instr_word[31:12] and imm_out[11:0] = 0.
- R6: For the I, S, B and J formats, every bit of imm_out above the top bit of the format's field equals instr_word[31]. That is bits 31..12 for I and S, 31..13 for B, and 31..21 for J. The extreme negative and positive offsets therefore come out as the full 32-bit two's-complement values.
- R7: For fmt_sel = 5, 6 or 7, imm_out is 0 for any instruction word.
- R8: Bits of instr_word that the selected format does not name, such as the opcode bits [6:0], have no effect on imm_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Instruction word to extract from |
| fmt_sel | input | 3 | Format code: 0 I, 1 S, 2 B, 3 J, 4 U, others unused |
| imm_out | output | 32 | Reassembled, sign-extended immediate |

## Verification
For each format, the bench takes an offset, encodes it into an instruction word, and fills every other bit with random junk. It then expects exactly that offset back. A swapped field would scramble the value. A sign fill taken from the wrong bit would turn the largest negative offsets into positive ones. A missing implied zero would make branch and jump offsets odd.

Opcode and register bits carry random values, so a lane that reads the wrong bits produces a mismatch. The U-format checks set every low instruction bit, so low bits leaking into the result show up at once. The unused codes are driven with random words, and any output that is not zero counts as a failure.

// File: rtl/imm_pkg.sv
package imm_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned NUM_FMT = 5;

  typedef enum logic [SEL_W-1:0] {
    FMT_I = 3'd0,
    FMT_S = 3'd1,
    FMT_B = 3'd2,
    FMT_J = 3'd3,
    FMT_U = 3'd4
  } imm_fmt_e;

  typedef logic [XLEN-1:0] word_t;

  // Spread bit 31 of the instruction above position top_bit.
  function automatic word_t sign_fill(input word_t raw, input word_t iw,
                                      input int unsigned top_bit);
    word_t r;
    r = raw;
    for (int unsigned k = 0; k < XLEN; k++) begin
      if (k > top_bit) r[k] = iw[XLEN-1];
    end
    return r;
  endfunction

  function automatic word_t build_i(input word_t iw);
    word_t r;
    r = '0;
    r[11:0] = iw[31:20];
    return sign_fill(r, iw, 11);
  endfunction

  function automatic word_t build_s(input word_t iw);
    word_t r;
    r = '0;
    r[11:5] = iw[31:25];
    r[4:0]  = iw[11:7];
    return sign_fill(r, iw, 11);
  endfunction

  function automatic word_t build_b(input word_t iw);
    word_t r;
    r = '0;
    r[12]   = iw[31];
    r[11]   = iw[7];
    r[10:5] = iw[30:25];
    r[4:1]  = iw[11:8];
    r[0]    = 1'b0;
    return sign_fill(r, iw, 12);
  endfunction

  function automatic word_t build_j(input word_t iw);
    word_t r;
    r = '0;
    r[20]    = iw[31];
    r[19:12] = iw[19:12];
    r[11]    = iw[20];
    r[10:1]  = iw[30:21];
    r[0]     = 1'b0;
    return sign_fill(r, iw, 20);
  endfunction

  function automatic word_t build_u(input word_t iw);
    word_t r;
    r = '0;
    r[31:12] = iw[31:12];
    return r;
  endfunction

endpackage

// File: rtl/imm_fmt_decode.sv
module imm_fmt_decode
  import imm_pkg::*;
#(
  parameter int unsigned SW = SEL_W,
  parameter int unsigned NF = NUM_FMT
) (
  input  logic [SW-1:0] fmt_sel,
  output logic [NF-1:0] fmt_hit,
  output logic          sel_valid
);

  always_comb begin
    fmt_hit = '0;
    for (int unsigned f = 0; f < NF; f++) begin
      if (fmt_sel == SW'(f)) fmt_hit[f] = 1'b1;
    end
  end

  assign sel_valid = (fmt_sel < SW'(NF));

  // R7: at most one format lane may be chosen, none for unused codes
  always_comb begin
    a_r7_hit_onehot: assert ($onehot0(fmt_hit));
    if (!sel_valid) begin
      a_r7_no_hit_when_unused: assert (fmt_hit == '0);
    end
  end

endmodule

// File: rtl/imm_lane.sv
module imm_lane
  import imm_pkg::*;
#(
  parameter int unsigned FMT = 0
) (
  input  logic [XLEN-1:0] instr_word,
  output logic [XLEN-1:0] lane_imm
);

  generate
    if (FMT == int'(FMT_I)) begin : g_i
      assign lane_imm = build_i(instr_word);
    end else if (FMT == int'(FMT_S)) begin : g_s
      assign lane_imm = build_s(instr_word);
    end else if (FMT == int'(FMT_B)) begin : g_b
      assign lane_imm = build_b(instr_word);
    end else if (FMT == int'(FMT_J)) begin : g_j
      assign lane_imm = build_j(instr_word);
    end else begin : g_u
      assign lane_imm = build_u(instr_word);
    end
  endgenerate

endmodule

// File: rtl/imm_onehot_mux.sv
module imm_onehot_mux #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 32
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] din,
  output logic [W-1:0]        dout
);

  always_comb begin
    dout = '0;
    for (int unsigned n = 0; n < N; n++) begin
      dout = dout | (din[n] & {W{sel[n]}});
    end
  end

  always_comb begin
    if (sel == '0) begin
      a_r7_empty_select_zero: assert (dout == '0);
    end
  end

endmodule

// File: rtl/imm_gen.sv
module imm_gen
  import imm_pkg::*;
(
  input  logic [31:0] instr_word,
  input  logic [2:0]  fmt_sel,
  output logic [31:0] imm_out
);

  logic [NUM_FMT-1:0]           fmt_hit;
  logic                         sel_valid;
  logic [NUM_FMT-1:0][XLEN-1:0] lane_imm;

  imm_fmt_decode #(.SW(SEL_W), .NF(NUM_FMT)) u_dec (
    .fmt_sel   (fmt_sel),
    .fmt_hit   (fmt_hit),
    .sel_valid (sel_valid)
  );

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_lane
    imm_lane #(.FMT(f)) u_lane (
      .instr_word (instr_word),
      .lane_imm   (lane_imm[f])
    );
  end

  imm_onehot_mux #(.N(NUM_FMT), .W(XLEN)) u_mux (
    .sel  (fmt_hit),
    .din  (lane_imm),
    .dout (imm_out)
  );

  always_comb begin
    if (fmt_sel == FMT_U) begin
      a_r5_upper_low_zero: assert (imm_out[11:0] == 12'h000);
    end
    if (fmt_sel == FMT_B || fmt_sel == FMT_J) begin
      a_r3_r4_even_offset: assert (imm_out[0] == 1'b0);
    end
    if (fmt_sel == FMT_I || fmt_sel == FMT_S) begin
      a_r6_sign_fill_is: assert (imm_out[31:11] == {21{instr_word[31]}});
    end
    if (fmt_sel == FMT_B) begin
      a_r6_sign_fill_b: assert (imm_out[31:12] == {20{instr_word[31]}});
    end
    if (fmt_sel == FMT_J) begin
      a_r6_sign_fill_j: assert (imm_out[31:20] == {12{instr_word[31]}});
    end
    if (!sel_valid) begin
      a_r7_unused_zero: assert (imm_out == 32'h0);
    end
  end

endmodule

// File: tb/imm_gen_test.sv
module imm_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_word = '0;
  logic [2:0]  fmt_sel = '0;
  logic [31:0] imm_out;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  imm_gen uut (.instr_word(instr_word), .fmt_sel(fmt_sel), .imm_out(imm_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (sel=%0d inst=%h)", req, act, exp, fmt_sel, instr_word);
    end
  endtask

  task automatic apply(input logic [2:0] s, input logic [31:0] w);
    @(posedge clk);
    fmt_sel    = s;
    instr_word = w;
    @(negedge clk);
  endtask

  // Encoders: place an offset into an instruction word, junk elsewhere.
  function automatic logic [31:0] enc_i(input int off, input logic [31:0] j);
    logic [31:0] o = off;
    return {o[11:0], j[19:0]};
  endfunction
  function automatic logic [31:0] enc_s(input int off, input logic [31:0] j);
    logic [31:0] o = off;
    return {o[11:5], j[24:12], o[4:0], j[6:0]};
  endfunction
  function automatic logic [31:0] enc_b(input int off, input logic [31:0] j);
    logic [31:0] o = off;
    return {o[12], o[10:5], j[24:12], o[4:1], o[11], j[6:0]};
  endfunction
  function automatic logic [31:0] enc_j(input int off, input logic [31:0] j);
    logic [31:0] o = off;
    return {o[20], o[10:1], o[11], o[19:12], j[11:0]};
  endfunction
  function automatic logic [31:0] enc_u(input logic [31:0] v, input logic [31:0] j);
    return {v[31:12], j[11:0]};
  endfunction

  task automatic run_i(input int off);
    apply(3'd0, enc_i(off, $urandom));
    check(off < 0 ? "R1/R6/R8" : "R1/R8", imm_out, off);
  endtask
  task automatic run_s(input int off);
    apply(3'd1, enc_s(off, $urandom));
    check(off < 0 ? "R2/R6/R8" : "R2/R8", imm_out, off);
  endtask
  task automatic run_b(input int off);
    apply(3'd2, enc_b(off, $urandom));
    check(off < 0 ? "R3/R6/R8" : "R3/R8", imm_out, off);
  endtask
  task automatic run_j(input int off);
    apply(3'd3, enc_j(off, $urandom));
    check(off < 0 ? "R4/R6/R8" : "R4/R8", imm_out, off);
  endtask
  task automatic run_u(input logic [31:0] v, input logic [31:0] j);
    apply(3'd4, enc_u(v, j));
    check("R5/R8", imm_out, {v[31:12], 12'h000});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset-state zero word", imm_out, 32'h0);

    run_i(-2048); run_i(2047); run_i(0); run_i(-1);
    run_s(-2048); run_s(2047); run_s(0); run_s(-1);
    run_b(-4096); run_b(4094); run_b(0); run_b(-2);
    run_j(-1048576); run_j(1048574); run_j(0); run_j(-2);
    run_u(32'h8000_0000, 32'hFFFF_FFFF);
    run_u(32'hFFFF_F000, 32'hFFFF_FFFF);
    run_u(32'h7FFF_F000, 32'h0000_0FFF);
    run_u(32'h0000_0000, 32'hFFFF_FFFF);

    for (int n = 0; n < 200; n++) begin
      run_i(int'($urandom_range(0, 4095)) - 2048);
      run_s(int'($urandom_range(0, 4095)) - 2048);
      run_b((int'($urandom_range(0, 4095)) - 2048) * 2);
      run_j((int'($urandom_range(0, 1048575)) - 524288) * 2);
      run_u($urandom, $urandom);
    end

    // R8: same immediate, opposite junk, same result
    for (int n = 0; n < 50; n++) begin
      int off = int'($urandom_range(0, 4095)) - 2048;
      apply(3'd0, enc_i(off, 32'h0));
      check("R8 junk zeros", imm_out, off);
      apply(3'd0, enc_i(off, 32'hFFFF_FFFF));
      check("R8 junk ones", imm_out, off);
    end

    for (int s = 5; s < 8; s++) begin
      apply(3'(s), 32'hFFFF_FFFF);
      check("R7 unused code all-ones", imm_out, 32'h0);
      for (int n = 0; n < 30; n++) begin
        apply(3'(s), $urandom);
        check("R7 unused code random", imm_out, 32'h0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule